// File: doc/BRIEF.md
# Audio Master-Clock Divider with Frame-Phase Monitor

This block runs on an audio master clock that is either 256 or 384 times the sample rate and turns it into a single internal enable that fires at 256 times the sample rate. When the master clock is the faster 384x version, the enable is high on two cycles out of every three, so the ratio is 2/3 and no second clock domain is needed. A free-running tick-phase counter advances on that enable. The generated bit clock (128x sample rate), frame clock (1x) and a 2x frame-sync strobe are read directly from bits of that counter. All outputs are plain signals in the master-clock domain. No clock is gated.

A monitor watches the active frame clock. In master mode this is the internal one. In slave mode it is an external pin, passed through a synchronizer. The frequency of the master clock must match the frame clock, but their relative phase may be anything. The monitor counts 256x ticks between consecutive rising frame edges. Any interval other than exactly 256 ticks asserts an auto-reset output for the downstream digital path, and so does a silence longer than 256 ticks. The auto-reset stays high until two consecutive correct intervals have been measured. It is also high from reset until lock is first gained.

Top module: `aclk_div_top`

## Requirements
- R1: With `rate_sel` = 0 (256x master clock), `tick_en` is high on every cycle.
- R2: With `rate_sel` = 1 (384x master clock), `tick_en` follows the repeating pattern high, high, low. The pattern starts on the first cycle after reset, so exactly two of every three cycles carry a tick.
- R3: `bclk_out` equals bit 0 of the count of ticks since reset. It toggles after every tick, which gives a period of 2 ticks (128x rate).
- R4: `lrclk_out` is high while the tick count modulo 256 is below 128 and low otherwise. Its rising edge recurs every 256 ticks, and `bclk_out` is low at that edge.
- R5: `fsync_out` is high while bit 6 of the tick count is 0, which gives two periods per frame (2x rate). It rises together with every rising edge of `lrclk_out`.
- R6: On a cycle without a tick, none of the three generated clocks changes on the following cycle.
- R7: With `master_mode` = 1 the monitor watches the internal `lrclk_out` and ignores `frame_in`. With `master_mode` = 0 it watches `frame_in`, passed through a two-stage synchronizer.
- R8: `auto_rst` falls only on the cycle after a measured rising-edge interval of exactly 256 ticks that completes the second consecutive correct interval.
- R9: A measured interval other than 256 ticks, whether shorter (for example 255) or longer (for example 257), raises `auto_rst` on the next cycle and clears the run of correct intervals.
- R10: If more than 256 ticks pass without a rising edge, `auto_rst` is raised without waiting for an edge. The next edge then only starts a new measurement.
- R11: A synchronous `rst` forces `tick_en` phase 0, tick count 0 (`bclk_out` = 0, `lrclk_out` = 1, `fsync_out` = 1) and `auto_rst` = 1.
- R12: The first rising edge after reset, or after a silence timeout, only arms the measurement and is never judged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 256x or 384x sample rate |
| rst | input | 1 | Synchronous active-high reset |
| rate_sel | input | 1 | 0: master clock is 256x, 1: master clock is 384x |
| master_mode | input | 1 | 1: monitor internal frame clock, 0: monitor `frame_in` |
| frame_in | input | 1 | External frame clock (slave mode), asynchronous |
| tick_en | output | 1 | Internal 256x-rate enable |
| bclk_out | output | 1 | Generated bit clock, 128x rate |
| lrclk_out | output | 1 | Generated frame clock, 1x rate |
| fsync_out | output | 1 | Generated frame-sync strobe, 2x rate |
| auto_rst | output | 1 | Auto-reset for the digital path, high while unlocked |

## Verification
On every cycle the assertions check the local rules: the cadence of the enable, that the clocks toggle or hold depending on the tick, the alignment of the frame edge with the bit clock and the sync strobe, that a bad interval or a timeout raises `auto_rst` at once, and that `auto_rst` never falls except just after a frame edge. Some properties are only visible in the bench scenarios because they depend on history: the exact phase of every generated clock across whole frames at both rates, the two-interval lock count, arm-only behaviour after a timeout, the 255/257-tick boundaries, and lock in slave mode at an arbitrary frame phase.

// File: rtl/aclk_pkg.sv
package aclk_pkg;

    // Default geometry: 2^8 = 256 ticks per frame, lock after 2 good frames
    localparam int unsigned TICK_W_DEF   = 8;
    localparam int unsigned LOCK_CNT_DEF = 2;
    localparam int unsigned SYNC_N_DEF   = 2;
    localparam int unsigned DEN_DEF      = 3;   // 2-of-3 enable pattern

    // Generated clock bundle
    typedef struct packed {
        logic bit_clk;
        logic frame_clk;
        logic sync2x;
    } clk_bundle_t;

    // Monitor state: waiting for an arming edge, or measuring intervals
    typedef enum logic [0:0] {
        MON_SEEK    = 1'b0,
        MON_MEASURE = 1'b1
    } mon_state_t;

    // Modulo-den increment
    function automatic int unsigned mod_next(input int unsigned cur,
                                             input int unsigned den);
        return (cur >= den - 1) ? 0 : cur + 1;
    endfunction

endpackage

// File: rtl/aclk_frac_en.sv
module aclk_frac_en
    import aclk_pkg::*;
#(
    parameter int unsigned DEN = DEN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_sel,
    output logic tick_en
);
    localparam int unsigned PW = (DEN > 1) ? $clog2(DEN) : 1;

    logic [PW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= '0;
        else     phase_q <= PW'(mod_next(int'(phase_q), DEN));
    end

    // Fractional mode drops the last cycle of each DEN-cycle group
    assign tick_en = !rate_sel || (phase_q != PW'(DEN - 1));

    // R2
    gap_then_tick_chk: assert property (@(posedge clk) disable iff (rst)
        (rate_sel && !tick_en) |=> tick_en);

endmodule

// File: rtl/aclk_clk_gen.sv
module aclk_clk_gen
    import aclk_pkg::*;
#(
    parameter int unsigned TICK_W = TICK_W_DEF
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick_en,
    output clk_bundle_t clks
);
    logic [TICK_W-1:0] tick_ph_q;

    always_ff @(posedge clk) begin
        if (rst)          tick_ph_q <= '0;
        else if (tick_en) tick_ph_q <= tick_ph_q + 1'b1;
    end

    always_comb begin
        clks.bit_clk   = tick_ph_q[0];
        clks.frame_clk = ~tick_ph_q[TICK_W-1];
        clks.sync2x    = ~tick_ph_q[TICK_W-2];
    end

    // R3
    bclk_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        tick_en |=> (clks.bit_clk != $past(clks.bit_clk)));

    // R6
    hold_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_en |=> $stable(clks));

    // R4
    frame_edge_bclk_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clks.frame_clk) |-> !clks.bit_clk);

    // R5
    sync_with_frame_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(clks.frame_clk) |-> $rose(clks.sync2x));

endmodule

// File: rtl/aclk_phase_mon.sv
module aclk_phase_mon
    import aclk_pkg::*;
#(
    parameter int unsigned TICK_W   = TICK_W_DEF,
    parameter int unsigned LOCK_CNT = LOCK_CNT_DEF,
    parameter int unsigned SYNC_N   = SYNC_N_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_en,
    input  logic master_mode,
    input  logic int_frame,
    input  logic ext_frame,
    output logic auto_rst
);
    localparam int unsigned FRAME_TICKS = 1 << TICK_W;
    localparam int unsigned GW          = TICK_W + 2;
    localparam int unsigned LW          = $clog2(LOCK_CNT + 1);

    logic [SYNC_N-1:0] sync_q;
    logic              prev_q;
    logic [GW-1:0]     gap_q;
    logic [GW-1:0]     total_w;
    logic [LW-1:0]     good_q;
    mon_state_t        state_q;
    logic              auto_rst_q;
    logic              frame_sel;
    logic              edge_w;
    logic              overrun_w;

    // Synchronizer chain for the external frame clock
    for (genvar i = 0; i < SYNC_N; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sync_q[0] <= 1'b0;
                else     sync_q[0] <= ext_frame;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sync_q[i] <= 1'b0;
                else     sync_q[i] <= sync_q[i-1];
            end
        end
    end

    assign frame_sel = master_mode ? int_frame : sync_q[SYNC_N-1];
    assign edge_w    = frame_sel && !prev_q;
    assign total_w   = gap_q + GW'(tick_en);
    assign overrun_w = !edge_w && (total_w > GW'(FRAME_TICKS));

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q     <= 1'b1;
            gap_q      <= '0;
            good_q     <= '0;
            state_q    <= MON_SEEK;
            auto_rst_q <= 1'b1;
        end else begin
            prev_q <= frame_sel;
            if (edge_w) begin
                gap_q <= '0;
                if (state_q == MON_SEEK) begin
                    state_q <= MON_MEASURE;
                end else if (total_w == GW'(FRAME_TICKS)) begin
                    if (good_q < LW'(LOCK_CNT)) good_q <= good_q + 1'b1;
                    if (good_q >= LW'(LOCK_CNT - 1)) auto_rst_q <= 1'b0;
                end else begin
                    good_q     <= '0;
                    auto_rst_q <= 1'b1;
                end
            end else if (overrun_w) begin
                gap_q      <= '0;
                good_q     <= '0;
                state_q    <= MON_SEEK;
                auto_rst_q <= 1'b1;
            end else begin
                gap_q <= total_w;
            end
        end
    end

    assign auto_rst = auto_rst_q;

    // R9
    bad_interval_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_w && state_q == MON_MEASURE && total_w != GW'(FRAME_TICKS))
        |=> auto_rst);

    // R10
    silence_chk: assert property (@(posedge clk) disable iff (rst)
        overrun_w |=> (auto_rst && state_q == MON_SEEK));

    // R8
    release_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(auto_rst) |-> $past(edge_w));

    // R12
    arm_only_chk: assert property (@(posedge clk) disable iff (rst)
        (edge_w && state_q == MON_SEEK) |=> $stable(auto_rst));

endmodule

// File: rtl/aclk_div_top.sv
module aclk_div_top
    import aclk_pkg::*;
#(
    parameter int unsigned TICK_W   = TICK_W_DEF,
    parameter int unsigned LOCK_CNT = LOCK_CNT_DEF,
    parameter int unsigned SYNC_N   = SYNC_N_DEF,
    parameter int unsigned DEN      = DEN_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_sel,
    input  logic master_mode,
    input  logic frame_in,
    output logic tick_en,
    output logic bclk_out,
    output logic lrclk_out,
    output logic fsync_out,
    output logic auto_rst
);
    clk_bundle_t clks;

    aclk_frac_en #(.DEN(DEN)) u_frac (
        .clk      (clk),
        .rst      (rst),
        .rate_sel (rate_sel),
        .tick_en  (tick_en)
    );

    aclk_clk_gen #(.TICK_W(TICK_W)) u_gen (
        .clk     (clk),
        .rst     (rst),
        .tick_en (tick_en),
        .clks    (clks)
    );

    aclk_phase_mon #(
        .TICK_W   (TICK_W),
        .LOCK_CNT (LOCK_CNT),
        .SYNC_N   (SYNC_N)
    ) u_mon (
        .clk         (clk),
        .rst         (rst),
        .tick_en     (tick_en),
        .master_mode (master_mode),
        .int_frame   (clks.frame_clk),
        .ext_frame   (frame_in),
        .auto_rst    (auto_rst)
    );

    assign bclk_out  = clks.bit_clk;
    assign lrclk_out = clks.frame_clk;
    assign fsync_out = clks.sync2x;

    // R1
    full_rate_chk: assert property (@(posedge clk) disable iff (rst)
        !rate_sel |=> (bclk_out != $past(bclk_out)));

    // R11
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (auto_rst && !bclk_out && lrclk_out && fsync_out));

endmodule

// File: tb/sim_aclk_div_top.sv
`timescale 1ns/1ps
module sim_aclk_div_top;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rate_sel = 1'b0;
    logic master_mode = 1'b0;
    logic frame_in = 1'b0;
    logic tick_en, bclk_out, lrclk_out, fsync_out, auto_rst;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    aclk_div_top u0 (
        .clk(clk), .rst(rst), .rate_sel(rate_sel), .master_mode(master_mode),
        .frame_in(frame_in), .tick_en(tick_en), .bclk_out(bclk_out),
        .lrclk_out(lrclk_out), .fsync_out(fsync_out), .auto_rst(auto_rst)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: act=%0d exp<=150000 cycles", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%b exp=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic do_reset(input logic rate, input logic mst);
        @(negedge clk);
        rst = 1'b1; rate_sel = rate; master_mode = mst; frame_in = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #1;
        chk(auto_rst,  1'b1, "R11 auto_rst");
        chk(bclk_out,  1'b0, "R11 bclk");
        chk(lrclk_out, 1'b1, "R11 lrclk");
        chk(fsync_out, 1'b1, "R11 fsync");
    endtask

    // One external frame: high first half, low second; optional two checks of auto_rst
    task automatic send_frame(input int len, input int ca, input logic ea,
                              input int cb, input logic eb, input string tag);
        for (int i = 0; i < len; i++) begin
            frame_in = (i < len / 2);
            #1;
            if (i == ca) chk(auto_rst, ea, tag);
            if (i == cb) chk(auto_rst, eb, tag);
            @(negedge clk);
        end
    endtask

    // Master-mode sweep: every output against an arithmetic tick model
    task automatic run_master(input logic rate);
        int nt = 0;
        int lockk;
        logic et;
        do_reset(rate, 1'b1);
        lockk = rate ? 1152 : 768;
        for (int k = 0; k < 1250; k++) begin
            et = rate ? ((k % 3) != 2) : 1'b1;
            frame_in = ((k / 77) % 2) != 0;   // R7: must be ignored in master mode
            #1;
            chk(tick_en, et, rate ? "R2 tick pattern" : "R1 tick every cycle");
            chk(bclk_out, nt[0], "R3 bclk");
            chk(lrclk_out, ~nt[7], "R4 lrclk");
            chk(fsync_out, ~nt[6], "R5 fsync");
            if (k == lockk - 8) chk(auto_rst, 1'b1, "R8 master before lock");
            if (k == lockk + 4) chk(auto_rst, 1'b0, "R7 R8 master lock");
            if (et) nt++;
            @(negedge clk);
        end
    endtask

    initial begin
        // R1..R6 at both rates
        run_master(1'b0);
        run_master(1'b1);

        // R7: slave mode with silent frame_in never locks
        do_reset(1'b0, 1'b0);
        for (int k = 0; k < 1000; k++) begin
            #1;
            if (k == 900) chk(auto_rst, 1'b1, "R7 slave ignores internal frame");
            @(negedge clk);
        end

        // Slave mode, 256x, arbitrary phase
        do_reset(1'b0, 1'b0);
        repeat (37) @(negedge clk);
        send_frame(256, 20, 1'b1, -1, 1'b0, "R12 first edge arms");
        send_frame(256, 20, 1'b1, -1, 1'b0, "R8 one good interval");
        send_frame(256, 20, 1'b0, -1, 1'b0, "R8 two good intervals lock");
        send_frame(255, 20, 1'b0, -1, 1'b0, "R8 still locked");
        send_frame(256, 20, 1'b1, -1, 1'b0, "R9 short 255");
        send_frame(256, 20, 1'b1, -1, 1'b0, "R9 relock needs two");
        send_frame(256, 20, 1'b0, -1, 1'b0, "R8 relocked");
        send_frame(257, 20, 1'b0, -1, 1'b0, "R8 locked before long");
        send_frame(256, 20, 1'b1, -1, 1'b0, "R9 long 257");
        send_frame(256, 20, 1'b1, -1, 1'b0, "R9 one good after long");
        send_frame(400, 20, 1'b0, 300, 1'b1, "R10 silence timeout");
        send_frame(256, 20, 1'b1, -1, 1'b0, "R12 edge after timeout");
        send_frame(256, 20, 1'b1, -1, 1'b0, "R12 arm only after timeout");
        send_frame(256, 20, 1'b0, -1, 1'b0, "R12 lock after rearm");

        // Slave mode, 384x: 384 cycles carry exactly 256 ticks
        do_reset(1'b1, 1'b0);
        repeat (11) @(negedge clk);
        send_frame(384, 20, 1'b1, -1, 1'b0, "R12 384 arm");
        send_frame(384, 20, 1'b1, -1, 1'b0, "R8 384 one good");
        send_frame(384, 20, 1'b0, -1, 1'b0, "R2 R8 384 lock");
        send_frame(390, 20, 1'b0, -1, 1'b0, "R8 384 locked");
        send_frame(384, 20, 1'b1, -1, 1'b0, "R9 384 wrong length");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule